// File: doc/BRIEF.md
# Interrupt Line to Message Delivery Engine

This block turns a set of interrupt input lines into message-signalled interrupts. Every pin has a 64-bit redirection entry held in a table that a neighbouring register block owns. The entry gives the pin's vector, delivery mode, destination, destination mode, input polarity, trigger mode, mask and in-service (remote-IRR) flag. The engine keeps a pending bit for each pin. Edge pins latch their pending bit on a rising request. Level pins let their pending bit follow the input. The engine then picks the lowest-numbered pin that may be served, composes an address/data pair from that pin's entry, and offers the pair on a valid/ready port.

A level pin that has been delivered asks the table owner to set its in-service flag. While that flag is set, further requests from the pin are coalesced: nothing is sent. The end-of-interrupt logic clears the flag. If the line is still asserted at that point, the pin is delivered again. Legacy line 0 is steered onto pin 2, and pin 0 has no source.

Top module: `irq_msg_router`

## Requirements
- R1: After reset, `msg_valid` is 0 and `pend_o` is all zero.
- R2: On an edge pin (entry bit 15 = 0), a rising request latches the pending bit only while the entry's mask (bit 16) is 0. A rising request seen while the mask is 1 is dropped and is not delivered after a later unmask.
- R3: On a level pin (bit 15 = 1), the pending bit follows the asserted state of the input, both set and clear, whatever the mask. Once a level request is withdrawn, no message is sent for it.
- R4: Entry bit 13 selects the input polarity: 0 means a high line is asserted and 1 means a low line is asserted.
- R5: Input line 0 drives pin 2, in OR with line 2. Lines 1 to NPINS-1 map one-to-one to pins. Pin 0 never becomes pending.
- R6: When several pins may be served, the lowest-numbered one is offered first.
- R7: The entry fields are: vector [7:0], delivery mode [10:8], destination mode [11], destination [63:48]. The message address is ADDR_BASE | destination<<4 | destination-mode<<2. The message data is vector | delivery-mode<<8 | trigger<<15.
- R8: Once `msg_valid` is high, it stays high with a stable address and data until `msg_ready` is sampled high. Only one message is in flight at a time.
- R9: When a handshake completes, an edge pin's pending bit is cleared. A level pin instead gets a one-cycle pulse on its bit of `rirr_set` and keeps its pending bit.
- R10: A level pin whose remote-IRR bit (bit 14) is 1 is not delivered. Once the bit returns to 0 while the pin is still pending, the pin is delivered again.
- R11: A masked pin is never offered. A level pin left pending under the mask is delivered once it is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | NPINS | Raw interrupt input lines |
| rte_flat | input | 64*NPINS | Redirection entries; pin p at bits [64p+63:64p] |
| pend_o | output | NPINS | Pending bit per pin |
| rirr_set | output | NPINS | One-cycle request to set a pin's remote-IRR flag |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted when high with msg_valid |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bench builds the block with its default values: 24 pins and base address 0xFEE00000. With 24 pins the line-0 remap to pin 2 can be exercised, as can the top pin 23 and a 5-bit pin index whose codes 24 to 31 must never be produced. The random phase pulses random subsets of the upper ten pins, with random delivery modes, destinations and ready stalls. This exercises ascending order and message composition across the full 16-bit destination.

// File: rtl/irq_msg_router.sv
module irq_msg_router #(
  parameter int          NPINS     = 24,
  parameter logic [31:0] ADDR_BASE = 32'hFEE0_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPINS-1:0]    irq_line,
  input  logic [64*NPINS-1:0] rte_flat,
  output logic [NPINS-1:0]    pend_o,
  output logic [NPINS-1:0]    rirr_set,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [31:0]         msg_addr,
  output logic [31:0]         msg_data
);
  localparam int IW = $clog2(NPINS);

  logic [NPINS-1:0] pin_raw, act, act_q, pend, pend_n, elig, clr;
  logic [NPINS-1:0] trig, mask, rirr;
  logic [IW-1:0]    cur_pin, sel;
  logic             found, fire, cur_level;
  logic [63:0]      ent_sel;

  always_comb begin
    pin_raw    = irq_line;
    pin_raw[0] = 1'b0;
    pin_raw[2] = irq_line[0] | irq_line[2];
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [63:0] ent;
    assign ent     = rte_flat[64*p +: 64];
    assign trig[p] = ent[15];
    assign mask[p] = ent[16];
    assign rirr[p] = ent[14];
    if (p == 0) begin : g_nosrc
      assign act[p] = 1'b0;
    end else begin : g_src
      assign act[p] = pin_raw[p] ^ ent[13];
    end
    assign pend_n[p] = trig[p] ? act[p]
                     : (pend[p] & ~clr[p]) | (act[p] & ~act_q[p] & ~mask[p]);
  end

  assign elig      = pend & ~mask & ~(trig & rirr);
  assign fire      = msg_valid & msg_ready;
  assign cur_level = msg_data[15];
  assign clr       = (fire & ~cur_level) ? ({{(NPINS-1){1'b0}}, 1'b1} << cur_pin) : '0;
  assign rirr_set  = (fire &  cur_level) ? ({{(NPINS-1){1'b0}}, 1'b1} << cur_pin) : '0;
  assign pend_o    = pend;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        sel   = IW'(i);
      end
    end
  end

  assign ent_sel = rte_flat[{sel, 6'b0} +: 64];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= '0;
      act_q     <= '0;
      msg_valid <= 1'b0;
      cur_pin   <= '0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      pend  <= pend_n;
      act_q <= act;
      if (fire) begin
        msg_valid <= 1'b0;
      end else if (!msg_valid && found) begin
        msg_valid <= 1'b1;
        cur_pin   <= sel;
        msg_addr  <= ADDR_BASE | {12'b0, ent_sel[63:48], 4'b0} | {29'b0, ent_sel[11], 2'b0};
        msg_data  <= {16'b0, ent_sel[15], 4'b0, ent_sel[10:8], ent_sel[7:0]};
      end
    end
  end
endmodule

module irq_msg_router_chk #(
  parameter int NPINS = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pend_o,
  input logic [NPINS-1:0] rirr_set,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [31:0]      msg_addr,
  input logic [31:0]      msg_data
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  assert_rirr_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rirr_set));

  assert_rirr_handshake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|rirr_set) |-> (msg_valid && msg_ready && msg_data[15]));

  assert_pin0_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_o[0]);
endmodule

bind irq_msg_router irq_msg_router_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .pend_o(pend_o), .rirr_set(rirr_set),
  .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data));

// File: tb/irq_msg_router_tb.sv
module irq_msg_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 24;

  logic clk = 1'b0, rst_n = 1'b0, rdy = 1'b1;
  logic [NP-1:0] lines = '0, pend_o, rirr_set, rirr_m = '0;
  logic [64*NP-1:0] tbl_flat;
  logic msg_valid;
  logic [31:0] msg_addr, msg_data;
  logic [63:0] cfg [NP];
  logic [63:0] q [$];
  int nchk = 0, nbad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_msg_router #(.NPINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_line(lines), .rte_flat(tbl_flat),
    .pend_o(pend_o), .rirr_set(rirr_set), .msg_valid(msg_valid),
    .msg_ready(rdy), .msg_addr(msg_addr), .msg_data(msg_data));

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      logic [63:0] e;
      e = cfg[p];
      e[14] = rirr_m[p];
      tbl_flat[64*p +: 64] = e;
    end
  end

  function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] dm,
      input logic dmode, input logic pol, input logic lvl, input logic msk,
      input logic [15:0] dest);
    logic [63:0] e = '0;
    e[7:0] = vec; e[10:8] = dm; e[11] = dmode; e[13] = pol;
    e[15] = lvl; e[16] = msk; e[63:48] = dest;
    return e;
  endfunction

  function automatic logic [63:0] exp_msg(input logic [63:0] e);
    logic [31:0] a, d;
    a = 32'hFEE0_0000 | (32'(e[63:48]) << 4) | (32'(e[11]) << 2);
    d = 32'(e[7:0]) | (32'(e[10:8]) << 8) | (32'(e[15]) << 15);
    return {a, d};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic tick();
    logic [NP-1:0] rs;
    if (msg_valid && rdy) q.push_back({msg_addr, msg_data});
    rs = rirr_set;
    @(negedge clk);
    rirr_m |= rs;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic expect_msg(input string req, input int pin);
    logic [63:0] m;
    if (q.size() == 0) begin
      chk(1'b0, req, 64'd0, exp_msg(cfg[pin]));
    end else begin
      m = q.pop_front();
      chk(m == exp_msg(cfg[pin]), req, m, exp_msg(cfg[pin]));
    end
  endtask

  task automatic expect_none(input string req);
    chk(q.size() == 0, req, 64'(q.size()), 64'd0);
    q.delete();
  endtask

  task automatic pulse(input logic [NP-1:0] which);
    lines = lines | which;
    tick();
    lines = lines & ~which;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    logic [31:0] held_a, held_d;
    void'($urandom(32'd4711));
    for (int p = 0; p < NP; p++)
      cfg[p] = mk(8'h20 + 8'(p), 3'(p % 8), p[0], 1'b0, 1'b0, 1'b0, 16'h1000 + 16'(p * 3));
    @(negedge clk);
    ticks(3);
    chk(msg_valid == 1'b0, "R1 valid", 64'(msg_valid), 0);
    chk(pend_o == '0, "R1 pend", 64'(pend_o), 0);
    rst_n = 1'b1;
    ticks(2);

    // R2 R7: unmasked edge
    pulse(24'(1) << 5); ticks(6);
    expect_msg("R2 R7 pin5", 5); expect_none("R2 single");
    chk(pend_o[5] == 1'b0, "R9 edge cleared", 64'(pend_o[5]), 0);

    // R2: masked edge dropped
    cfg[6][16] = 1'b1;
    pulse(24'(1) << 6); ticks(5);
    chk(pend_o[6] == 1'b0, "R2 masked not latched", 64'(pend_o[6]), 0);
    cfg[6][16] = 1'b0; ticks(5);
    expect_none("R2 masked dropped");

    // R5: line 0 to pin 2
    pulse(24'(1)); ticks(6);
    expect_msg("R5 line0->pin2", 2); expect_none("R5 single");
    chk(pend_o[0] == 1'b0, "R5 pin0", 64'(pend_o[0]), 0);

    // R6 R8: stall and order
    rdy = 1'b0;
    pulse((24'(1) << 9) | (24'(1) << 4)); ticks(4);
    chk(msg_valid == 1'b1, "R8 valid held", 64'(msg_valid), 1);
    chk(msg_data[7:0] == 8'h24, "R6 lowest first", 64'(msg_data[7:0]), 64'h24);
    held_a = msg_addr; held_d = msg_data;
    ticks(5);
    chk(msg_valid && msg_addr == held_a && msg_data == held_d, "R8 stable",
        {msg_addr, msg_data}, {held_a, held_d});
    rdy = 1'b1; ticks(8);
    expect_msg("R6 first pin4", 4); expect_msg("R6 second pin9", 9); expect_none("R6 extra");

    // R3 R9 R10: level pin 10
    cfg[10][15] = 1'b1;
    lines[10] = 1'b1; ticks(8);
    expect_msg("R9 level msg", 10); expect_none("R10 single");
    chk(rirr_m[10] == 1'b1, "R9 rirr_set pulse", 64'(rirr_m[10]), 1);
    chk(pend_o[10] == 1'b1, "R9 level keeps pending", 64'(pend_o[10]), 1);
    ticks(8);
    expect_none("R10 coalesced");
    rirr_m[10] = 1'b0; ticks(6);
    expect_msg("R10 redeliver", 10); expect_none("R10 single again");
    lines[10] = 1'b0; ticks(3);
    chk(pend_o[10] == 1'b0, "R3 level clears", 64'(pend_o[10]), 0);
    rirr_m[10] = 1'b0; ticks(6);
    expect_none("R3 withdrawn");

    // R4 R11: active-low masked level pin 13
    cfg[13] = mk(8'h2D, 3'd1, 1'b1, 1'b1, 1'b1, 1'b1, 16'hBEEF);
    ticks(3);
    chk(pend_o[13] == 1'b1, "R4 low asserted", 64'(pend_o[13]), 1);
    expect_none("R11 masked held");
    lines[13] = 1'b1; ticks(3);
    chk(pend_o[13] == 1'b0, "R4 high deasserted", 64'(pend_o[13]), 0);
    lines[13] = 1'b0; ticks(3);
    cfg[13][16] = 1'b0; ticks(6);
    expect_msg("R11 unmask delivers", 13); expect_none("R11 single");
    lines[13] = 1'b1; ticks(3);
    rirr_m[13] = 1'b0; ticks(3);
    expect_none("R4 clean");

    // R6 R7 R8: random subsets of pins 14..23
    for (int it = 0; it < 20; it++) begin
      logic [9:0] bits;
      for (int p = 14; p < NP; p++)
        cfg[p] = mk(8'h20 + 8'(p), 3'($urandom), 1'($urandom), 1'b0, 1'b0, 1'b0, 16'($urandom));
      bits = 10'($urandom);
      if (it == 0) bits = 10'h3FF;
      pulse(24'(bits) << 14);
      for (int k = 0; k < 30; k++) begin
        rdy = 1'($urandom);
        tick();
      end
      rdy = 1'b1; ticks(30);
      for (int p = 0; p < 10; p++)
        if (bits[p]) expect_msg("R6 R7 random", p + 14);
      expect_none("R8 random no extra");
    end

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule